// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital side of an eight-input successive-approximation converter. Software programs a control word through a plain read/write register port. The word selects which inputs take part and divides the system clock down to a converter clock. It also sets the result width from 10 down to 3 bits, powers the converter on and off, and picks how a conversion begins. A conversion can start at once on command, on a chosen edge of one of five external trigger lines, or continuously in a scanning mode. In scanning mode the selected inputs are converted over and over without software involvement.

The analog converter sits outside the block behind a small synchronous port. The sequencer pulses a start strobe and presents the input number and the bit count. The converter returns a result word with a one-cycle ready strobe. Each finished result goes into a per-input data register and into a shared most-recent-result register. These registers carry done and overrun flags that reading clears. A status word gathers all the flags, and an interrupt output is raised from the done flags through a per-input enable mask and a master enable bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word, interrupt enable, status and all data registers read 0, `irq` is low and no `cnv_start` occurs.
- R2: The control word at address 0 holds these fields, and any other bit reads back 0.
  - [7:0] input select mask.
  - [15:8] divider.
  - [16] scan enable.
  - [19:17] width code.
  - [21] power-on.
  - [26:24] start code.
  - [27] falling-edge select.
- R3: While power-on is set, `cnv_clk_en` pulses once every divider+1 system cycles. While power-on is clear it stays low.
- R4: With power-on clear, no conversion starts, whatever the other fields hold.
- R5: With scan off, start code 1 runs exactly one conversion on the lowest-numbered selected input. The start field then reads back 0 while the other fields keep their values.
- R6: With scan off, start codes 2 to 6 begin a conversion on an edge of `trig_in[code-2]`. The edge is rising when bit 27 is 0 and falling when it is 1, and the line passes through a two-flop synchronizer first. Edges on unselected lines, and edges arriving while a conversion runs, start nothing.
- R7: With scan on, the selected inputs are converted in ascending order. After the highest selected input the scan wraps to the lowest, and it begins with the lowest.
- R8: `cnv_bits` equals 10 minus the width code. The stored result keeps only the top `cnv_bits` bits of `cnv_result` and zeroes the rest.
- R9: The data register for input n at address 8+n reads {done[31], overrun[30], 14'b0, result[15:6], 6'b0}. Reading it clears that input's done and overrun flags.
- R10: A result that lands on an input whose done flag is still set, and is not being read in that cycle, sets that input's overrun flag.
- R11: The most-recent-result register at address 3 reads {done[31], overrun[30], 3'b0, input[26:24], 8'b0, result[15:6], 6'b0}. It follows the same done, overrun and clear-on-read rules.
- R12: The status word at address 2 reads {15'b0, irq[16], overrun[15:8], done[7:0]}.
- R13: The interrupt enable register at address 1 holds bits [8:0]. One cycle after a change, `irq` equals bit 8 AND the OR over n of (done[n] AND bit n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (drives clear-on-read) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| trig_in | input | 5 | External trigger lines, asynchronous |
| cnv_clk_en | output | 1 | Converter clock enable pulse |
| cnv_start | output | 1 | One-cycle conversion start strobe |
| cnv_chan | output | 3 | Input being converted |
| cnv_bits | output | 4 | Result width in bits for this conversion |
| cnv_result | input | 10 | Converter result, left-justified |
| cnv_ready | input | 1 | One-cycle result-valid strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the converter answers each start strobe with exactly one ready pulse. They also assume it never raises ready without a conversion in flight. The bench's converter model meets both by responding only to `cnv_start` and by counting width+1 converter clock enables before its single ready cycle. The assertions also take it that the divider may change at any moment, so they never pin the spacing of enables across a reprogramming. Random rounds pick one input, a width code and a small divider per conversion. Trigger lines and control writes change only while no conversion is pending, so every start the bench observes traces back to one programmed cause.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int RES_W  = 10;
  localparam int NTRIG  = 5;
  localparam int DIV_W  = 8;
  localparam int WSEL_W = 3;
  localparam logic [31:0] CTRL_WMASK = 32'h0F2F_FFFF;
  localparam logic [31:0] IEN_WMASK  = 32'h0000_01FF;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;

  function automatic logic [CH_W-1:0] first_sel(input logic [NCH-1:0] mask);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (mask[i]) r = CH_W'(i);
    return r;
  endfunction

  function automatic logic [CH_W-1:0] next_sel(input logic [NCH-1:0] mask,
                                               input logic [CH_W-1:0] cur);
    logic [CH_W-1:0] r;
    logic            found;
    r     = first_sel(mask);
    found = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (!found && mask[i] && (CH_W'(i) > cur)) begin
        r     = CH_W'(i);
        found = 1'b1;
      end
    return r;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == div);
    cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig,
  input  logic [2:0]       mode,
  input  logic             fall,
  output logic             hit
);
  logic [NTRIG-1:0] s1_q, s2_q, s3_q, edges;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= trig;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end

  always_comb begin
    edges = fall ? (~s2_q & s3_q) : (s2_q & ~s3_q);
    hit   = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (mode == 3'(i + 2)) hit = edges[i];
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pdn_i,
  input  logic            burst_i,
  input  logic [2:0]      mode_i,
  input  logic [NCH-1:0]  mask_i,
  input  logic            trig_hit,
  input  logic            cnv_ready,
  output logic            cnv_start,
  output logic [CH_W-1:0] cnv_chan,
  output logic            res_valid,
  output logic            clr_now
);
  seq_st_e         st_q, st_d;
  logic            scan_q, scan_d, go, idle, single_go;
  logic [CH_W-1:0] chan_q, chan_d, pick;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    single_go = !burst_i && ((mode_i == 3'd1) || trig_hit);
    go        = idle && pdn_i && (|mask_i) && (burst_i || single_go);
    pick      = (burst_i && scan_q) ? next_sel(mask_i, chan_q) : first_sel(mask_i);
    clr_now   = go && !burst_i && (mode_i == 3'd1);
    res_valid = !idle && cnv_ready;
    scan_d    = burst_i && (scan_q || go);
    chan_d    = go ? pick : chan_q;
    st_d      = st_q;
    if (go)             st_d = ST_BUSY;
    else if (res_valid) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      scan_q    <= 1'b0;
      chan_q    <= '0;
      cnv_start <= 1'b0;
    end else begin
      st_q      <= st_d;
      scan_q    <= scan_d;
      chan_q    <= chan_d;
      cnv_start <= go;
    end

  assign cnv_chan = chan_q;

  // R4
  start_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> $past(pdn_i));
  // R5
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);
  // R7
  start_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> $past(mask_i) != '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [CH_W-1:0]           wr_chan,
  input  logic [RES_W-1:0]          wr_data,
  input  logic [NCH-1:0]            ch_clr,
  input  logic                      g_clr,
  output logic [NCH-1:0]            done_q,
  output logic [NCH-1:0]            ovr_q,
  output logic [NCH-1:0][RES_W-1:0] res_q,
  output logic                      g_done_q,
  output logic                      g_ovr_q,
  output logic [CH_W-1:0]           g_chan_q,
  output logic [RES_W-1:0]          g_res_q
);
  logic [NCH-1:0]            done_d, ovr_d;
  logic [NCH-1:0][RES_W-1:0] res_d;
  logic                      g_done_d, g_ovr_d;
  logic [CH_W-1:0]           g_chan_d;
  logic [RES_W-1:0]          g_res_d;

  always_comb begin
    done_d   = done_q & ~ch_clr;
    ovr_d    = ovr_q & ~ch_clr;
    res_d    = res_q;
    g_done_d = g_done_q && !g_clr;
    g_ovr_d  = g_ovr_q && !g_clr;
    g_chan_d = g_chan_q;
    g_res_d  = g_res_q;
    if (wr) begin
      ovr_d[wr_chan]  = ovr_d[wr_chan] | (done_q[wr_chan] & ~ch_clr[wr_chan]);
      done_d[wr_chan] = 1'b1;
      res_d[wr_chan]  = wr_data;
      g_ovr_d         = g_ovr_d || (g_done_q && !g_clr);
      g_done_d        = 1'b1;
      g_chan_d        = wr_chan;
      g_res_d         = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q   <= '0;
      ovr_q    <= '0;
      res_q    <= '0;
      g_done_q <= 1'b0;
      g_ovr_q  <= 1'b0;
      g_chan_q <= '0;
      g_res_q  <= '0;
    end else begin
      done_q   <= done_d;
      ovr_q    <= ovr_d;
      res_q    <= res_d;
      g_done_q <= g_done_d;
      g_ovr_q  <= g_ovr_d;
      g_chan_q <= g_chan_d;
      g_res_q  <= g_res_d;
    end

  // R9
  one_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done_q & ~$past(done_q)) <= 1);
  // R10
  ovr_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q & ~done_q) == '0);
  // R11
  g_ovr_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_ovr_q |-> g_done_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NTRIG-1:0]  trig_in,
  output logic              cnv_clk_en,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  output logic [3:0]        cnv_bits,
  input  logic [RES_W-1:0]  cnv_result,
  input  logic              cnv_ready,
  output logic              irq
);
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  logic rst_i;
  assign rst_i = rs2_q;

  logic [31:0] ctrl_q, ctrl_d, ien_q, ien_d;
  logic        irq_d, trig_hit, res_valid, clr_now, g_clr;
  logic [NCH-1:0]            ch_clr, done_q, ovr_q;
  logic [NCH-1:0][RES_W-1:0] res_q;
  logic                      g_done_q, g_ovr_q;
  logic [CH_W-1:0]           g_chan_q;
  logic [RES_W-1:0]          g_res_q, kept;

  logic [NCH-1:0]    f_mask;
  logic [DIV_W-1:0]  f_div;
  logic              f_burst, f_pdn, f_fall;
  logic [WSEL_W-1:0] f_res;
  logic [2:0]        f_mode;
  assign f_mask  = ctrl_q[7:0];
  assign f_div   = ctrl_q[15:8];
  assign f_burst = ctrl_q[16];
  assign f_res   = ctrl_q[19:17];
  assign f_pdn   = ctrl_q[21];
  assign f_mode  = ctrl_q[26:24];
  assign f_fall  = ctrl_q[27];

  assign cnv_bits = 4'(RES_W) - 4'(f_res);
  assign kept     = cnv_result & ({RES_W{1'b1}} << f_res);

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_we && bus_addr == 4'd0) ctrl_d = bus_wdata & CTRL_WMASK;
    else if (clr_now)               ctrl_d[26:24] = 3'd0;
    ien_d  = (bus_we && bus_addr == 4'd1) ? (bus_wdata & IEN_WMASK) : ien_q;
    irq_d  = ien_q[8] && |(done_q & ien_q[NCH-1:0]);
    ch_clr = (bus_re && bus_addr[3]) ? (NCH'(1) << bus_addr[2:0]) : '0;
    g_clr  = bus_re && (bus_addr == 4'd3);
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      irq    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      irq    <= irq_d;
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3])
      bus_rdata = {done_q[bus_addr[2:0]], ovr_q[bus_addr[2:0]], 14'b0,
                   res_q[bus_addr[2:0]], 6'b0};
    else
      case (bus_addr[2:0])
        3'd0:    bus_rdata = ctrl_q;
        3'd1:    bus_rdata = ien_q;
        3'd2:    bus_rdata = {15'b0, irq, ovr_q, done_q};
        3'd3:    bus_rdata = {g_done_q, g_ovr_q, 3'b0, g_chan_q, 8'b0, g_res_q, 6'b0};
        default: bus_rdata = '0;
      endcase
  end

  adc_clk_div u_div (.clk(clk), .rst_n(rst_i), .en(f_pdn), .div(f_div),
                     .tick(cnv_clk_en));

  adc_trig_edge u_trig (.clk(clk), .rst_n(rst_i), .trig(trig_in), .mode(f_mode),
                        .fall(f_fall), .hit(trig_hit));

  adc_scan_fsm u_fsm (.clk(clk), .rst_n(rst_i), .pdn_i(f_pdn), .burst_i(f_burst),
                      .mode_i(f_mode), .mask_i(f_mask), .trig_hit(trig_hit),
                      .cnv_ready(cnv_ready), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
                      .res_valid(res_valid), .clr_now(clr_now));

  adc_result_bank u_bank (.clk(clk), .rst_n(rst_i), .wr(res_valid), .wr_chan(cnv_chan),
                          .wr_data(kept), .ch_clr(ch_clr), .g_clr(g_clr),
                          .done_q(done_q), .ovr_q(ovr_q), .res_q(res_q),
                          .g_done_q(g_done_q), .g_ovr_q(g_ovr_q),
                          .g_chan_q(g_chan_q), .g_res_q(g_res_q));

  // R13
  irq_master_gate_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !ien_q[8] |=> !irq);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0]  trig_in = '0;
  logic        cnv_clk_en, cnv_start, irq;
  logic [2:0]  cnv_chan;
  logic [3:0]  cnv_bits;
  logic [9:0]  cnv_result;
  logic        cnv_ready;

  int errs = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .cnv_clk_en(cnv_clk_en), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
    .cnv_bits(cnv_bits), .cnv_result(cnv_result), .cnv_ready(cnv_ready), .irq(irq));

  // converter model
  logic       m_busy;
  logic [3:0] m_cnt, m_bits;
  logic [2:0] m_chan;
  logic [9:0] m_val;
  int         start_cnt, rdy_cnt;
  logic [2:0] slog [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cnt <= '0; m_bits <= '0; m_chan <= '0; m_val <= '0;
      cnv_ready <= 1'b0; cnv_result <= '0; start_cnt <= 0; rdy_cnt <= 0;
    end else begin
      cnv_ready <= 1'b0;
      if (cnv_start) begin
        m_busy <= 1'b1; m_cnt <= '0; m_bits <= cnv_bits; m_chan <= cnv_chan;
        m_val  <= 10'($urandom);
        slog[start_cnt % 16] <= cnv_chan;
        start_cnt <= start_cnt + 1;
      end else if (m_busy && cnv_clk_en) begin
        if (m_cnt == m_bits) begin
          cnv_ready <= 1'b1; cnv_result <= m_val; m_busy <= 1'b0;
          rdy_cnt <= rdy_cnt + 1;
        end else m_cnt <= m_cnt + 1'b1;
      end
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    finish_up();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_conv;
    int c0 = rdy_cnt;
    for (int i = 0; i < 3000 && rdy_cnt == c0; i++) @(negedge clk);
    idle(3);
  endtask

  task automatic wait_quiet;
    for (int i = 0; i < 3000 && (m_busy || cnv_start); i++) @(negedge clk);
    idle(4);
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [7:0] mask, input logic [7:0] dv,
      input logic bst, input logic [2:0] res, input logic pdn, input logic [2:0] mode,
      input logic fall);
    return {4'b0, fall, mode, 2'b0, pdn, 1'b0, res, bst, dv, mask};
  endfunction

  function automatic logic [31:0] exp_ch(input logic d, input logic o,
      input logic [9:0] v, input logic [2:0] res);
    return {d, o, 14'b0, v & (10'h3FF << res), 6'b0};
  endfunction

  logic [31:0] r;
  int s0, n;

  initial begin
    void'($urandom(32'd1234));
    idle(5); rst_n = 1'b1; idle(5);

    // R1 reset state
    rd(4'd0, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(4'd2, r); chk(r == 0, "R1 status", r, 0);
    rd(4'd3, r); chk(r == 0, "R1 global", r, 0);
    chk(irq == 0 && start_cnt == 0, "R1 irq/start", {irq, 31'(start_cnt)}, 0);

    // R2 field storage, R4 powered off
    wr(4'd0, 32'hFFDF_FFFF); idle(20);
    rd(4'd0, r); chk(r == 32'h0F0F_FFFF, "R2 ctrl readback", r, 32'h0F0F_FFFF);
    chk(start_cnt == 0, "R4 no start when off", start_cnt, 0);

    // R3 divider
    wr(4'd0, mk_ctrl(8'h00, 8'd3, 0, 3'd0, 1, 3'd0, 0));
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cnv_clk_en) n++; end
    chk(n == 10, "R3 enable rate div=3", n, 10);
    wr(4'd0, 32'h0);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cnv_clk_en) n++; end
    chk(n == 0, "R3 enable held off", n, 0);

    // R5 lowest selected input
    wr(4'd0, mk_ctrl(8'h6C, 8'd1, 0, 3'd0, 1, 3'd1, 0)); wait_conv();
    chk(m_chan == 3'd2, "R5 lowest selected", m_chan, 2);
    rd(4'd10, r); chk(r == exp_ch(1, 0, m_val, 3'd0), "R9 ch2 data", r, exp_ch(1, 0, m_val, 3'd0));
    rd(4'd3, r);

    // random single conversions
    for (int it = 0; it < 6; it++) begin
      logic [2:0] ch, res; logic [7:0] dv; logic [31:0] ex;
      ch = 3'($urandom % 8); res = 3'($urandom % 8); dv = 8'($urandom % 3);
      s0 = start_cnt;
      wr(4'd0, mk_ctrl(8'(1) << ch, dv, 0, res, 1, 3'd1, 0)); wait_conv(); idle(4);
      chk(start_cnt == s0 + 1 && m_chan == ch, "R5 single channel", {29'(start_cnt - s0), m_chan}, {29'd1, ch});
      chk(m_bits == 4'(10 - res), "R8 bit count", m_bits, 4'(10 - res));
      rd(4'd0, r);
      chk(r == mk_ctrl(8'(1) << ch, dv, 0, res, 1, 3'd0, 0), "R5 start field cleared", r,
          mk_ctrl(8'(1) << ch, dv, 0, res, 1, 3'd0, 0));
      ex = exp_ch(1, 0, m_val, res);
      rd({1'b1, ch}, r); chk(r == ex, "R8 R9 channel result", r, ex);
      ex = {1'b1, 1'b0, 3'b0, ch, 8'b0, m_val & (10'h3FF << res), 6'b0};
      rd(4'd3, r); chk(r == ex, "R11 global result", r, ex);
      rd({1'b1, ch}, r); chk(r[31:30] == 0, "R9 read clears", r, 0);
      rd(4'd3, r); chk(r[31:30] == 0, "R11 read clears", r, 0);
    end

    // R6 triggers
    wr(4'd0, mk_ctrl(8'h10, 8'd0, 0, 3'd0, 1, 3'd4, 0)); idle(3);
    s0 = start_cnt;
    trig_in[0] = 1'b1; idle(4); trig_in[0] = 1'b0; idle(12);
    chk(start_cnt == s0, "R6 unselected line ignored", start_cnt - s0, 0);
    trig_in[2] = 1'b1; idle(3); trig_in[2] = 1'b0; wait_conv();
    chk(start_cnt == s0 + 1 && m_chan == 3'd4, "R6 rising edge start", start_cnt - s0, 1);
    wr(4'd0, mk_ctrl(8'h10, 8'd0, 0, 3'd0, 1, 3'd3, 1)); idle(3);
    s0 = start_cnt;
    trig_in[1] = 1'b1; idle(12);
    chk(start_cnt == s0, "R6 rising ignored in falling mode", start_cnt - s0, 0);
    trig_in[1] = 1'b0; wait_conv();
    chk(start_cnt == s0 + 1, "R6 falling edge start", start_cnt - s0, 1);
    rd(4'd12, r); rd(4'd3, r);

    // R7 scan order, R10 overrun
    s0 = start_cnt;
    wr(4'd0, mk_ctrl(8'hA2, 8'd0, 1, 3'd7, 1, 3'd0, 0));
    for (int i = 0; i < 3000 && start_cnt < s0 + 4; i++) @(negedge clk);
    wr(4'd0, mk_ctrl(8'hA2, 8'd0, 0, 3'd7, 1, 3'd0, 0)); wait_quiet();
    chk(slog[s0 % 16] == 1 && slog[(s0 + 1) % 16] == 5 && slog[(s0 + 2) % 16] == 7
        && slog[(s0 + 3) % 16] == 1, "R7 ascending wrap",
        {slog[s0 % 16], slog[(s0 + 1) % 16], slog[(s0 + 2) % 16], slog[(s0 + 3) % 16]}, 12'o1571);
    rd(4'd2, r);
    chk(r[7:0] == 8'hA2, "R12 done bits", r[7:0], 8'hA2);
    chk(r[9] == 1'b1, "R10 overrun ch1 in status", r[15:8], 8'h02);

    // R13 interrupt gating
    wr(4'd1, 32'h002); idle(3);
    chk(irq == 0, "R13 master enable off", irq, 0);
    wr(4'd1, 32'h102); idle(3);
    chk(irq == 1, "R13 enabled done", irq, 1);
    rd(4'd2, r); chk(r[16] == 1, "R12 irq bit", r, 32'h0001_0000);
    rd(4'd9, r); chk(r[31:30] == 2'b11, "R10 ch1 done+overrun", r[31:30], 2'b11);
    idle(3);
    chk(irq == 0, "R13 cleared after read", irq, 0);
    rd(4'd9, r); chk(r[31:30] == 0, "R9 ch1 cleared", r[31:30], 0);
    rd(4'd13, r); rd(4'd15, r); wr(4'd1, 32'h0);
    rd(4'd2, r); chk(r[7:0] == 0, "R12 all done cleared", r[7:0], 0);

    // R4 power off blocks start
    s0 = start_cnt;
    wr(4'd0, mk_ctrl(8'h01, 8'd0, 0, 3'd0, 0, 3'd1, 0)); idle(20);
    chk(start_cnt == s0, "R4 start code with power off", start_cnt - s0, 0);

    finish_up();
  end
endmodule